// File: doc/BRIEF.md
# Chained Start/Done Controller with Downstream Stall

This block wraps a fixed-latency compute payload in a start/idle/ready/done control shell. An upstream agent raises `start` with an operand. The block takes that operand and runs for a set number of cycles. It then raises `done` with the computed value on `result`. The payload computes `operand * KMUL + KADD`, truncated to `W` bits.

A `cont` input lets the consumer of the result stall the block once a transaction is complete. While `cont` is low, `done` stays asserted as a level and `result` is frozen. The transaction only retires in a cycle where `cont` is high. If `start` is also high in that cycle, the next operand is taken at once and the block never passes through idle.

The `ready` output is a strobe that marks the cycle in which an operand is taken. That lets the block sit in a chain: the downstream stage takes `done` as its `start`, `result` as its operand, and returns its own `ready` as this stage's `cont`.

Top module: `hs_chain_ctrl`

## Requirements
- R1: After reset, `idle` is 1, `done` is 0, `result` is 0, and `ready` is 0 while `start` is low.
- R2: While `idle` is 1, a high `start` makes `ready` 1 in that same cycle, the operand is captured at that clock edge, and `idle` is 0 from the next cycle.
- R3: `done` rises exactly `LAT` clock edges after the edge that captured the operand. At that point `result` equals `operand * KMUL + KADD` modulo 2^W, and `result` changes only when `done` rises.
- R4: While `done` is 1 and `cont` is 0, `ready` is 0, and in the next cycle `done` is still 1 and `result` is unchanged.
- R5: When `done` and `cont` are both 1 and `start` is 1, `ready` is 1, the new operand is captured at that edge, and in the next cycle `idle` and `done` are both 0.
- R6: When `done` and `cont` are both 1 and `start` is 0, `done` is 0 and `idle` is 1 in the next cycle.
- R7: `ready` is never 1 while the block is computing (`idle` = 0 and `done` = 0).
- R8: With two instances chained (upstream `done` to downstream `start`, upstream `result` to downstream operand, downstream `ready` to upstream `cont`), every operand accepted upstream comes out of the downstream stage. Each operand produces exactly one output, the outputs appear in acceptance order, and each equals the payload function applied twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a transaction with `operand` |
| cont | input | 1 | Downstream can take the result (active high) |
| operand | input | W | Argument sampled when `ready` is high |
| idle | output | 1 | No transaction in progress or held |
| ready | output | 1 | Operand is taken at the coming edge |
| done | output | 1 | Result valid; held while `cont` is low |
| result | output | W | Return value of the last completed transaction |

## Verification
The bound checker watches, on every cycle, the handshake relations between the ports:
- `ready` is suppressed while busy or stalled;
- `done` and `result` are frozen under a stall;
- idle and done behave correctly on release, both with and without a following start;
- the completion latency is exact;
- `result` changes only when `done` rises.

Only the bench scenarios can show the end-to-end properties of a two-stage chain under random stalls and random gaps between operands. These are that no result is lost or duplicated, that the order is kept, and that the payload values are correct.

// File: rtl/hs_chain_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the chained start/done controller.
// Assumes: a three-phase control cycle (waiting, computing, holding a result).
package hs_chain_pkg;

    // Control phases of the wrapper
    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,   // no transaction, idle asserted
        PH_BUSY = 2'd1,   // payload computing
        PH_HOLD = 2'd2    // result valid, waiting for downstream acceptance
    } hs_phase_t;

endpackage

// File: rtl/hs_chain_timer.sv
`timescale 1ns/1ps
// Module: hs_chain_timer
// Counts the fixed payload latency. Reloads when an operand is accepted and
// flags expiry on the last busy cycle. Assumes LAT >= 1.
module hs_chain_timer #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,     // operand accepted this cycle
    input  logic busy,     // controller is in the computing phase
    output logic expire    // last computing cycle
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(LAT - 1);

    logic [CW-1:0] remain;

    // Reload on acceptance, count down while computing
    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= RELOAD;
        else if (busy && remain != '0)
            remain <= remain - 1'b1;
    end

    // Expiry is the busy cycle in which the count has reached zero
    always_comb expire = busy && (remain == '0);

endmodule

// File: rtl/hs_chain_fsm.sv
`timescale 1ns/1ps
// Module: hs_chain_fsm
// Control sequencer: waiting -> computing -> holding. Leaves the holding phase
// only when cont is high, and chains straight into a new transaction if start
// is high in that cycle. Assumes start/cont are synchronous to clk.
module hs_chain_fsm
    import hs_chain_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cont,
    input  logic expire,      // payload latency elapsed
    output logic accept,      // operand captured at this edge
    output logic finish,      // result captured at this edge
    output logic busy,
    output logic idle,
    output logic done
);
    hs_phase_t phase, phase_nx;

    // Acceptance: from waiting, or from holding once downstream has taken the result
    always_comb accept = start && ((phase == PH_WAIT) || (phase == PH_HOLD && cont));

    // Completion strobe towards the return register
    always_comb finish = (phase == PH_BUSY) && expire;

    // Next-phase selection
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_WAIT: if (accept) phase_nx = PH_BUSY;
            PH_BUSY: if (expire) phase_nx = PH_HOLD;
            PH_HOLD: if (cont)   phase_nx = accept ? PH_BUSY : PH_WAIT;
            default:             phase_nx = PH_WAIT;
        endcase
    end

    // Phase register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_WAIT;
        else        phase <= phase_nx;
    end

    // Status decode from the phase register
    always_comb begin
        busy = (phase == PH_BUSY);
        idle = (phase == PH_WAIT);
        done = (phase == PH_HOLD);
    end

endmodule

// File: rtl/hs_chain_datapath.sv
`timescale 1ns/1ps
// Module: hs_chain_datapath
// Operand latch and return-value register around the payload op*KMUL+KADD.
// The return register loads only on finish, so it stays frozen while the
// controller holds done.
module hs_chain_datapath #(
    parameter int W    = 16,
    parameter int KMUL = 5,
    parameter int KADD = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept,
    input  logic         finish,
    input  logic [W-1:0] operand,
    output logic [W-1:0] result
);
    localparam logic [W-1:0] MUL_C = W'(KMUL);
    localparam logic [W-1:0] ADD_C = W'(KADD);

    logic [W-1:0] op_q;
    logic [W-1:0] calc;

    // Capture the argument at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)      op_q <= '0;
        else if (accept) op_q <= operand;
    end

    // Payload arithmetic, modulo 2^W
    always_comb calc = W'(op_q * MUL_C + ADD_C);

    // Return register: written once per transaction
    always_ff @(posedge clk) begin
        if (!rst_n)      result <= '0;
        else if (finish) result <= calc;
    end

endmodule

// File: rtl/hs_chain_ctrl.sv
`timescale 1ns/1ps
// Module: hs_chain_ctrl (top)
// Start/idle/ready/done wrapper with a downstream continue input around a
// fixed-latency payload. ready is combinational from start/cont and marks the
// cycle in which the operand is taken; it may drive an upstream cont directly.
module hs_chain_ctrl #(
    parameter int W    = 16,
    parameter int LAT  = 3,
    parameter int KMUL = 5,
    parameter int KADD = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cont,
    input  logic [W-1:0] operand,
    output logic         idle,
    output logic         ready,
    output logic         done,
    output logic [W-1:0] result
);
    logic accept, finish, busy, expire;

    // Control sequencer
    hs_chain_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .cont(cont), .expire(expire),
        .accept(accept), .finish(finish), .busy(busy), .idle(idle), .done(done)
    );

    // Latency counter
    hs_chain_timer #(.LAT(LAT)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(accept), .busy(busy), .expire(expire)
    );

    // Operand and return-value storage
    hs_chain_datapath #(.W(W), .KMUL(KMUL), .KADD(KADD)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .finish(finish),
        .operand(operand), .result(result)
    );

    // The acceptance strobe is the block's ready output
    always_comb ready = accept;

endmodule

// File: rtl/hs_chain_checker.sv
`timescale 1ns/1ps
// Module: hs_chain_checker
// Port-level protocol checks for hs_chain_ctrl, attached by bind.
// Uses its own edge counter for the latency window.
module hs_chain_checker #(
    parameter int W   = 16,
    parameter int LAT = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         cont,
    input logic         idle,
    input logic         ready,
    input logic         done,
    input logic [W-1:0] result
);
    int edges_since_accept;

    // Edges elapsed since the last accepted operand
    always_ff @(posedge clk) begin
        if (!rst_n)     edges_since_accept <= 0;
        else if (ready) edges_since_accept <= 0;
        else if (!done) edges_since_accept <= edges_since_accept + 1;
    end

    AST_ACCEPT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n) idle && start |=> !idle); // R2
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> edges_since_accept == LAT); // R3
    AST_RESULT_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) !$stable(result) |-> $rose(done)); // R3
    AST_HOLD_KEEPS_DONE: assert property (@(posedge clk) disable iff (!rst_n) done && !cont |=> done && $stable(result)); // R4
    AST_HOLD_NO_READY: assert property (@(posedge clk) disable iff (!rst_n) done && !cont |-> !ready); // R4
    AST_CHAIN_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done && cont && start |=> !idle && !done); // R5
    AST_RELEASE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done && cont && !start |=> idle && !done); // R6
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n) !idle && !done |-> !ready); // R7

endmodule

bind hs_chain_ctrl hs_chain_checker #(.W(W), .LAT(LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cont(cont), .idle(idle),
    .ready(ready), .done(done), .result(result)
);

// File: tb/hs_chain_ctrl_test.sv
`timescale 1ns/1ps
// Bench: two chained instances; the upstream stage's cont comes from the
// downstream stage's ready. Random stalls and gaps plus directed corners.
module hs_chain_ctrl_test;
    localparam int PERIOD = 10;
    localparam int W = 16;
    localparam int LAT_A = 3;
    localparam int LAT_B = 2;
    localparam int KMUL = 5;
    localparam int KADD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_a = 1'b0;
    logic cont_b = 1'b0;
    logic [W-1:0] arg_a = '0;
    logic idle_a, ready_a, done_a, idle_b, ready_b, done_b;
    logic [W-1:0] res_a, res_b;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_q[$];
    bit acc_a, del_b, rel_a, st_a, hold_b, pdone_a;
    logic [W-1:0] pres_b;
    int a_lat = 0;

    always #(PERIOD/2) clk = ~clk;

    hs_chain_ctrl #(.W(W), .LAT(LAT_A), .KMUL(KMUL), .KADD(KADD)) uut (
        .clk(clk), .rst_n(rst_n), .start(start_a), .cont(ready_b), .operand(arg_a),
        .idle(idle_a), .ready(ready_a), .done(done_a), .result(res_a)
    );

    hs_chain_ctrl #(.W(W), .LAT(LAT_B), .KMUL(KMUL), .KADD(KADD)) sink_stage (
        .clk(clk), .rst_n(rst_n), .start(done_a), .cont(cont_b), .operand(res_a),
        .idle(idle_b), .ready(ready_b), .done(done_b), .result(res_b)
    );

    // Model of the payload
    function automatic logic [W-1:0] pay(input logic [W-1:0] x);
        return W'(x * W'(KMUL) + W'(KADD));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock cycle: sample before the edge, then check the consequences
    task automatic tick();
        #1;
        acc_a = ready_a; del_b = done_b && cont_b; rel_a = done_a && ready_b;
        st_a = start_a; hold_b = done_b && !cont_b; pres_b = res_b; pdone_a = done_a;
        if (idle_a && start_a) chk(ready_a == 1'b1, "R2 ready in idle", ready_a, 1);
        if (!idle_a && !done_a) chk(ready_a == 1'b0, "R7 ready while busy", ready_a, 0);
        if (hold_b) chk(ready_b == 1'b0, "R4 ready under stall", ready_b, 0);
        @(posedge clk); @(negedge clk);
        a_lat = acc_a ? 0 : a_lat + 1;
        if (acc_a) begin
            exp_q.push_back(pay(pay(arg_a)));
            chk(idle_a == 1'b0, "R2 idle after accept", idle_a, 0);
        end
        if (!pdone_a && done_a) chk(a_lat == LAT_A, "R3 latency", a_lat, LAT_A);
        if (del_b) begin
            if (exp_q.size() == 0) chk(1'b0, "R8 extra result", int'(pres_b), -1);
            else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                chk(pres_b == e, "R8/R3 delivered value", pres_b, e);
            end
        end
        if (hold_b) chk(done_b && res_b == pres_b, "R4 hold stable", res_b, pres_b);
        if (rel_a && st_a) chk(!idle_a && !done_a, "R5 chained restart", {idle_a, done_a}, 0);
        if (rel_a && !st_a) chk(idle_a && !done_a, "R6 idle after release", {idle_a, done_a}, 2);
    endtask

    initial begin
        #(PERIOD * 200000);
        chk(1'b0, "watchdog", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state on both stages
        chk(idle_a && !done_a && !ready_a && res_a == 0, "R1 upstream reset", {idle_a, done_a, ready_a}, 4);
        chk(idle_b && !done_b && !ready_b && res_b == 0, "R1 downstream reset", {idle_b, done_b, ready_b}, 4);

        // Directed: one item with the sink stalled, then released
        arg_a = 16'd7; start_a = 1'b1; cont_b = 1'b0;
        tick();
        start_a = 1'b0;
        repeat (LAT_A + LAT_B + 6) tick();
        chk(done_b == 1'b1 && res_b == pay(pay(16'd7)), "R4 sink holding", res_b, pay(pay(16'd7)));
        cont_b = 1'b1; tick(); cont_b = 1'b0;
        chk(idle_b && !done_b, "R6 sink idle after release", {idle_b, done_b}, 2);

        // Directed: back-to-back items, corner operands
        cont_b = 1'b1;
        for (int i = 0; i < 4; i++) begin
            arg_a = (i == 0) ? '1 : (i == 1) ? '0 : W'(i * 1000);
            start_a = 1'b1;
            do tick(); while (!acc_a);
        end
        start_a = 1'b0;

        // Random phase: gaps on the source, stalls on the sink
        for (int c = 0; c < 4000; c++) begin
            cont_b = ($urandom % 3) != 0;
            tick();
            if (acc_a) begin
                if ($urandom % 2) arg_a = W'($urandom); else start_a = 1'b0;
            end else if (!start_a && ($urandom % 4) == 0) begin
                arg_a = W'($urandom); start_a = 1'b1;
            end
        end

        // Drain and confirm nothing was lost
        start_a = 1'b0; cont_b = 1'b1;
        repeat (40) tick();
        chk(exp_q.size() == 0, "R8 nothing lost", exp_q.size(), 0);
        chk(idle_a && idle_b, "R6 both idle after drain", {idle_a, idle_b}, 3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule